// File: doc/BRIEF.md
# Two-Run Launch Sequencer

This block is a controller that makes a subordinate worker machine execute twice for each start request. A one-cycle-or-longer start flag seen while the controller is idle opens the first run phase. On entry to each phase the controller raises a registered launch request. A companion pulse generator turns that request into a start strobe of fixed width for the worker, and the end of the strobe withdraws the request. The controller also presents a phase-specific data byte to the worker.

The controller then waits on the worker. It needs to see the worker's busy line rise and then fall, with the worker's period flag and transfer-in-progress flag both low. It also waits for its own request to have ended. When all of that holds it moves to the second phase, and after the second run it goes back to idle. If busy never rises after a launch, a timeout returns the controller to idle. Everything runs on one clock with a synchronous active-high reset.

Top module: `runseq_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `launch_o`, `req_o`, `active_o` and `data_o` are all zero.
- R2: When `go_i` is high at a clock edge while the controller is idle, after that edge `active_o` and `req_o` are 1 and `data_o` equals `DATA_A` (default 8'h77).
- R3: Each launch strobe on `launch_o` is high for exactly `PULSE_W` consecutive cycles (default 4), and it starts at the clock edge after the one that raised `req_o`.
- R4: `req_o` falls at the same clock edge as the launch strobe ends.
- R5: After a launch, a busy line that stays low is not taken as completion: the controller stays in its phase with its data byte unchanged.
- R6: A phase is only left while `wk_period_i` and `wk_xfer_i` are both low. If either is high, the controller keeps waiting. Once both are low after busy has fallen, the next phase is entered at the following edge.
- R7: On entering the second phase, `data_o` becomes `DATA_B` (default 8'h88), `req_o` rises again, and a second launch strobe follows.
- R8: When the second run completes, the controller returns to idle with `active_o`, `req_o` and `data_o` at zero. Exactly two launch strobes are issued per accepted start.
- R9: `go_i` is ignored while the controller is not idle. It causes no extra strobe and no change of data byte.
- R10: If busy has not risen `TMO_CYC` cycles (default 64) after a phase was entered, the controller returns to idle with all outputs low.
- R11: The controller does not leave a phase while its own request is still high, even if the worker has already finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| go_i | input | 1 | Start request, accepted only while idle |
| wk_busy_i | input | 1 | Worker busy, high while the worker operates |
| wk_period_i | input | 1 | Worker period flag, blocks phase exit while high |
| wk_xfer_i | input | 1 | Worker data-in-progress flag, blocks phase exit while high |
| launch_o | output | 1 | Fixed-width start strobe to the worker |
| data_o | output | 8 | Data byte for the current phase, zero when idle |
| req_o | output | 1 | Launch request, high from phase entry until the strobe ends |
| active_o | output | 1 | High whenever the controller is not idle |

## Verification
A wrong phase register shows at once on `data_o`, because the byte is a direct image of the phase: an early advance gives 8'h88 in the edge after the faulty transition. A lost or stale request changes the number or the width of the strobes on `launch_o`, and this shows within `PULSE_W`+2 cycles of a phase entry. A broken busy-rise tracking or timeout shows as an early or missing drop of `active_o`, measured against the exact cycle count of `TMO_CYC`. A missing exit condition shows as a data byte that changes while the worker's flags are still high.

// File: rtl/runseq_pkg.sv
package runseq_pkg;

    localparam int RS_DW = 8;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_A_ARM,
        RS_A_DONE,
        RS_B_ARM,
        RS_B_DONE
    } rs_state_e;

    typedef struct packed {
        rs_state_e              st;
        logic                   req;
        logic [RS_DW-1:0]       data;
    } rs_ctrl_s;

endpackage

// File: rtl/runseq_pulse.sv
module runseq_pulse #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic pulse_o,
    output logic last_o
);
    localparam int CW = $clog2(PULSE_W + 1);

    logic prev_d, prev_q;
    logic fire;

    always_comb begin
        prev_d = req_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    generate
        if (PULSE_W == 1) begin : g_single
            logic on_d, on_q;
            assign fire = req_i & ~prev_q & ~on_q;
            always_comb begin
                on_d = fire;
            end
            always_ff @(posedge clk) begin
                if (rst) on_q <= 1'b0;
                else     on_q <= on_d;
            end
            assign pulse_o = on_q;
            assign last_o  = on_q;
        end else begin : g_count
            logic [CW-1:0] cnt_d, cnt_q;
            assign fire = req_i & ~prev_q & (cnt_q == '0);
            always_comb begin
                cnt_d = cnt_q;
                if (fire)
                    cnt_d = CW'(PULSE_W);
                else if (cnt_q != '0)
                    cnt_d = cnt_q - 1'b1;
            end
            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end
            assign pulse_o = (cnt_q != '0);
            assign last_o  = (cnt_q == CW'(1));
        end
    endgenerate

endmodule

// File: rtl/runseq_timer.sv
module runseq_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i)
            cnt_d = (cnt_q == TW'(LIMIT - 1)) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expire_o = run_i & (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/runseq_fsm.sv
module runseq_fsm
    import runseq_pkg::*;
#(
    parameter logic [RS_DW-1:0] DATA_A = 8'h77,
    parameter logic [RS_DW-1:0] DATA_B = 8'h88
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             busy_i,
    input  logic             period_i,
    input  logic             xfer_i,
    input  logic             pulse_last_i,
    input  logic             tmo_i,
    output logic             req_o,
    output logic [RS_DW-1:0] data_o,
    output logic             active_o,
    output logic             arm_o
);
    rs_ctrl_s ctl_d, ctl_q;
    logic     exit_ok;

    // A phase may end only when the worker is quiet and our own strobe is over.
    assign exit_ok = ~busy_i & ~period_i & ~xfer_i & ~ctl_q.req;

    always_comb begin
        ctl_d = ctl_q;
        if (pulse_last_i)
            ctl_d.req = 1'b0;
        unique case (ctl_q.st)
            RS_IDLE: begin
                if (go_i) begin
                    ctl_d.st   = RS_A_ARM;
                    ctl_d.req  = 1'b1;
                    ctl_d.data = DATA_A;
                end
            end
            RS_A_ARM: begin
                if (busy_i) begin
                    ctl_d.st = RS_A_DONE;
                end else if (tmo_i) begin
                    ctl_d.st   = RS_IDLE;
                    ctl_d.req  = 1'b0;
                    ctl_d.data = '0;
                end
            end
            RS_A_DONE: begin
                if (exit_ok) begin
                    ctl_d.st   = RS_B_ARM;
                    ctl_d.req  = 1'b1;
                    ctl_d.data = DATA_B;
                end
            end
            RS_B_ARM: begin
                if (busy_i) begin
                    ctl_d.st = RS_B_DONE;
                end else if (tmo_i) begin
                    ctl_d.st   = RS_IDLE;
                    ctl_d.req  = 1'b0;
                    ctl_d.data = '0;
                end
            end
            RS_B_DONE: begin
                if (exit_ok) begin
                    ctl_d.st   = RS_IDLE;
                    ctl_d.req  = 1'b0;
                    ctl_d.data = '0;
                end
            end
            default: begin
                ctl_d.st   = RS_IDLE;
                ctl_d.req  = 1'b0;
                ctl_d.data = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st   <= RS_IDLE;
            ctl_q.req  <= 1'b0;
            ctl_q.data <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_o    = ctl_q.req;
    assign data_o   = ctl_q.data;
    assign active_o = (ctl_q.st != RS_IDLE);
    assign arm_o    = (ctl_q.st == RS_A_ARM) | (ctl_q.st == RS_B_ARM);

endmodule

// File: rtl/runseq_ctrl.sv
module runseq_ctrl
    import runseq_pkg::*;
#(
    parameter logic [RS_DW-1:0] DATA_A  = 8'h77,
    parameter logic [RS_DW-1:0] DATA_B  = 8'h88,
    parameter int               PULSE_W = 4,
    parameter int               TMO_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             wk_busy_i,
    input  logic             wk_period_i,
    input  logic             wk_xfer_i,
    output logic             launch_o,
    output logic [RS_DW-1:0] data_o,
    output logic             req_o,
    output logic             active_o
);
    logic pulse_last;
    logic tmo;
    logic arm;

    runseq_fsm #(
        .DATA_A (DATA_A),
        .DATA_B (DATA_B)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .go_i         (go_i),
        .busy_i       (wk_busy_i),
        .period_i     (wk_period_i),
        .xfer_i       (wk_xfer_i),
        .pulse_last_i (pulse_last),
        .tmo_i        (tmo),
        .req_o        (req_o),
        .data_o       (data_o),
        .active_o     (active_o),
        .arm_o        (arm)
    );

    runseq_pulse #(
        .PULSE_W (PULSE_W)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_o),
        .pulse_o (launch_o),
        .last_o  (pulse_last)
    );

    runseq_timer #(
        .LIMIT (TMO_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (arm),
        .expire_o (tmo)
    );

endmodule

// File: rtl/runseq_chk.sv
module runseq_chk #(
    parameter logic [7:0] DATA_A  = 8'h77,
    parameter logic [7:0] DATA_B  = 8'h88,
    parameter int         PULSE_W = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       go_i,
    input logic       wk_period_i,
    input logic       wk_xfer_i,
    input logic       launch_o,
    input logic [7:0] data_o,
    input logic       req_o,
    input logic       active_o
);
    logic [15:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst)           wcnt_q <= '0;
        else if (launch_o) wcnt_q <= wcnt_q + 1'b1;
        else               wcnt_q <= '0;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !active_o |-> (data_o == '0) && !req_o && !launch_o);

    a_r2_go_enters_first: assert property (@(posedge clk) disable iff (rst)
        (!active_o && go_i) |=> (active_o && req_o && data_o == DATA_A));

    a_r3_strobe_follows_req: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |=> launch_o);

    a_r3_strobe_width: assert property (@(posedge clk) disable iff (rst)
        $fell(launch_o) |-> (wcnt_q == 16'(PULSE_W)));

    a_r4_req_ends_with_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(launch_o) |-> $fell(req_o));

    a_r11_strobe_inside_req: assert property (@(posedge clk) disable iff (rst)
        launch_o |-> req_o);

    a_r6_flags_hold_phase: assert property (@(posedge clk) disable iff (rst)
        (data_o == DATA_A && (wk_period_i || wk_xfer_i)) |=> (data_o != DATA_B));

    a_r9_go_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (active_o && go_i && data_o == DATA_B) |=> (data_o != DATA_A));

endmodule

bind runseq_ctrl runseq_chk #(
    .DATA_A  (DATA_A),
    .DATA_B  (DATA_B),
    .PULSE_W (PULSE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go_i),
    .wk_period_i (wk_period_i),
    .wk_xfer_i   (wk_xfer_i),
    .launch_o    (launch_o),
    .data_o      (data_o),
    .req_o       (req_o),
    .active_o    (active_o)
);

// File: tb/sim_runseq_ctrl.sv
`timescale 1ns/1ps
module sim_runseq_ctrl;
    localparam int         W   = 4;
    localparam int         TMO = 64;
    localparam logic [7:0] DA  = 8'h77;
    localparam logic [7:0] DB  = 8'h88;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic wk_busy = 1'b0;
    logic wk_period = 1'b0;
    logic wk_xfer = 1'b0;
    logic launch;
    logic [7:0] data;
    logic req;
    logic active;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int bad_w = 0;
    int run_len = 0;
    int wk_runs = 0;
    bit wk_en = 1'b0;
    int wk_delay = 2;
    int wk_len = 5;
    bit seen = 1'b0;

    always #10 clk = ~clk;

    runseq_ctrl #(
        .DATA_A (DA), .DATA_B (DB), .PULSE_W (W), .TMO_CYC (TMO)
    ) u0 (
        .clk (clk), .rst (rst), .go_i (go), .wk_busy_i (wk_busy),
        .wk_period_i (wk_period), .wk_xfer_i (wk_xfer),
        .launch_o (launch), .data_o (data), .req_o (req), .active_o (active)
    );

    // strobe monitor
    always @(negedge clk) begin
        if (launch) run_len++;
        else if (run_len != 0) begin
            if (run_len != W) bad_w++;
            pulses++;
            run_len = 0;
        end
    end

    // worker responder
    always begin
        @(negedge clk);
        if (wk_en && launch && !seen) begin
            seen = 1'b1;
            repeat (wk_delay) @(negedge clk);
            wk_busy = 1'b1;
            repeat (wk_len) @(negedge clk);
            wk_busy = 1'b0;
            wk_runs++;
        end
        if (!launch) seen = 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic go_pulse();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    task automatic wait_idle(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (!active) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!launch && !req && !active && data == 0, "R1 in reset", data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!launch && !req && !active && data == 0, "R1 after release", {active, req, launch}, 0);
    endtask

    task automatic t_timing();
        int bad;
        wk_en = 1'b1; wk_delay = 8; wk_len = 5;
        pulses = 0; bad_w = 0; bad = 0;
        go_pulse();
        chk(active && req && data == DA && !launch, "R2 phase one entry", data, DA);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            if (!(launch && req)) bad++;
        end
        chk(bad == 0, "R3 strobe high for width", bad, 0);
        @(negedge clk);
        chk(!launch, "R3 strobe ends", launch, 0);
        chk(!req, "R4 req drops with strobe", req, 0);
        wait_idle(1000);
        chk(pulses == 2, "R8 two strobes", pulses, 2);
        chk(bad_w == 0, "R3 every strobe width", bad_w, 0);
    endtask

    task automatic t_run(input int dly, input int len);
        bit saw_b;
        int bad;
        wk_en = 1'b1; wk_delay = dly; wk_len = len;
        pulses = 0; saw_b = 1'b0; bad = 0;
        go_pulse();
        for (int i = 0; i < 3000; i++) begin
            if (!active) break;
            if (data == DB && !saw_b) begin
                saw_b = 1'b1;
                chk(req, "R7 request on second entry", req, 1);
                chk(pulses == 1, "R7 one strobe before phase two", pulses, 1);
            end
            if (!saw_b && data != DA) bad++;
            @(negedge clk);
        end
        chk(saw_b, "R7 second phase data", saw_b, 1);
        chk(bad == 0, "R2 first phase data held", bad, 0);
        chk(!active && !req && data == 0, "R8 back to idle", data, 0);
        chk(pulses == 2, "R8 two strobes per start", pulses, 2);
    endtask

    task automatic t_timeout();
        int bad;
        wk_en = 1'b0; pulses = 0; bad = 0;
        go_pulse();
        for (int n = 2; n <= TMO; n++) begin
            @(negedge clk);
            if (!active || data != DA) bad++;
        end
        chk(bad == 0, "R5 low busy not completion", bad, 0);
        @(negedge clk);
        chk(!active && !req && data == 0, "R10 timeout to idle", active, 0);
        chk(pulses == 1, "R10 single strobe", pulses, 1);
    endtask

    task automatic t_flags();
        int runs0;
        wk_en = 1'b1; wk_delay = 2; wk_len = 3; pulses = 0;
        wk_period = 1'b1;
        runs0 = wk_runs;
        go_pulse();
        for (int i = 0; i < 200; i++) begin
            if (wk_runs != runs0) break;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(active && data == DA, "R6 period flag holds phase", data, DA);
        wk_period = 1'b0; wk_xfer = 1'b1;
        repeat (10) @(negedge clk);
        chk(active && data == DA, "R6 xfer flag holds phase", data, DA);
        wk_xfer = 1'b0;
        @(negedge clk);
        chk(data == DB, "R6 advance when flags clear", data, DB);
        wait_idle(1000);
        chk(pulses == 2 && !active, "R8 idle after flag test", pulses, 2);
    endtask

    task automatic t_go_ignored();
        wk_en = 1'b1; wk_delay = 3; wk_len = 10; pulses = 0;
        go_pulse();
        repeat (2) @(negedge clk);
        go_pulse();
        chk(data == DA, "R9 go in phase one ignored", data, DA);
        for (int i = 0; i < 500; i++) begin
            if (data == DB) break;
            @(negedge clk);
        end
        go_pulse();
        chk(data == DB, "R9 go in phase two ignored", data, DB);
        wait_idle(1000);
        repeat (5) @(negedge clk);
        chk(pulses == 2 && !active, "R9 no extra strobe", pulses, 2);
    endtask

    task automatic t_short();
        wk_en = 1'b1; wk_delay = 0; wk_len = 1; pulses = 0;
        go_pulse();
        repeat (W) @(negedge clk);
        chk(launch && data == DA, "R11 held while request high", data, DA);
        wait_idle(1000);
        chk(pulses == 2 && !active, "R11 both runs completed", pulses, 2);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_timing();
        t_run(1, 4);
        t_run(12, 20);
        for (int k = 0; k < 4; k++) t_run($urandom_range(0, 15), $urandom_range(1, 30));
        t_timeout();
        t_flags();
        t_go_ignored();
        t_short();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule